// File: doc/BRIEF.md
# Buffered Input Capture Channel

This block is a single input-capture channel of a timer. It watches one pin, synchronizes it, and recognises the transitions chosen by a two-bit edge-select field. On each recognised transition it records the current value of a free-running timer in a capture register. It also counts recognised transitions in a small saturating pulse accumulator and raises a sticky capture flag.

A mode bit selects one of two buffering policies. In queue mode, every new capture first moves the previous capture into a holding register, so software can read the last two timestamps. In latch mode, pin edges only refresh the capture register. A strobe from an external modulus down-counter then takes a snapshot: the capture register and the accumulator are copied into their holding registers, and the accumulator restarts from zero. The strobe fires when that counter reaches zero or when zero is written to it.

Top module: `bufcap_channel`

## Requirements
- R1: After reset, the capture register, the holding register, the accumulator, the accumulator holding copy and the capture flag all read zero.
- R2: The edge-select field is decoded as 00 = no transition recognised, 01 = rising only, 10 = falling only, 11 = both. With 00, pin activity changes neither the capture register nor the accumulator nor the flag.
- R3: In queue mode (mode bit 0), a recognised transition stores the timer value in the capture register and moves the old capture value into the holding register. This happens on the third rising clock edge after the pin changes (two synchronizer stages plus the edge register). The timer value stored is the one present just before that edge.
- R4: In latch mode (mode bit 1), a recognised transition updates the capture register but leaves the holding register unchanged.
- R5: In latch mode, either strobe input (counter reached zero, or zero written) copies the capture register into the holding register and the accumulator into its holding copy on the next clock edge.
- R6: A latch event clears the accumulator. If a recognised transition occurs in the same clock, the holding copies take the values from before that transition, and the accumulator ends at 1.
- R7: The accumulator adds one per recognised transition in both modes and stays at 0xFF once it has reached it.
- R8: Every recognised transition sets the capture flag. A high flag-clear input clears it. When a set and a clear fall in the same clock, the set wins.
- R9: In queue mode, the strobe inputs have no effect on the holding register, the accumulator or its holding copy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| timer_val | input | 16 | Free-running timer value |
| pin_in | input | 1 | Capture pin, asynchronous |
| edge_sel | input | 2 | Transition select: 00 off, 01 rise, 10 fall, 11 both |
| latch_mode | input | 1 | 0 = queue mode, 1 = latch mode |
| mdc_zero | input | 1 | Strobe: modulus down-counter reached zero |
| mdc_wzero | input | 1 | Strobe: zero written to the modulus count register |
| flag_clr | input | 1 | Write-one-to-clear for the capture flag |
| cap_val | output | 16 | Capture register |
| hold_val | output | 16 | Holding register |
| pacc_val | output | 8 | Pulse accumulator |
| pacc_hold | output | 8 | Pulse accumulator holding copy |
| cap_flag | output | 1 | Capture flag |

## Verification
A pin change is acted on at the third rising edge after it is driven. Strobe and flag-clear inputs act at the very next rising edge. The bench drives every input on the falling edge. A cycle model in the bench carries the pin through two sync stages and an edge stage and computes the expected registers for each rising edge. Outputs are compared on the following falling edge, so each comparison lands exactly one half-cycle after the edge on which the result is due.

// File: rtl/bufcap_pkg.sv
package bufcap_pkg;

    // Transition select encoding
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    localparam int unsigned DEF_TIMER_W = 16;
    localparam int unsigned DEF_ACC_W   = 8;
    localparam int unsigned DEF_SYNC    = 2;

endpackage

// File: rtl/bufcap_edge_det.sv
module bufcap_edge_det
    import bufcap_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_in,
    input  logic [1:0] edge_sel,
    output logic       valid_edge
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } det_state_t;

    det_state_t st_d, st_q;
    logic       synced;
    logic       rise;
    logic       fall;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin_in};
        st_d.prev = st_q.sync[SYNC_STAGES-1];
        synced    = st_q.sync[SYNC_STAGES-1];
        rise      = synced & ~st_q.prev;
        fall      = ~synced & st_q.prev;
        unique case (edge_sel_e'(edge_sel))
            EDGE_RISE: valid_edge = rise;
            EDGE_FALL: valid_edge = fall;
            EDGE_BOTH: valid_edge = rise | fall;
            default:   valid_edge = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/bufcap_accum.sv
module bufcap_accum #(
    parameter int unsigned ACC_W = bufcap_pkg::DEF_ACC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_evt,
    input  logic             latch_evt,
    output logic [ACC_W-1:0] acc,
    output logic [ACC_W-1:0] acc_hold
);

    localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};
    localparam logic [ACC_W-1:0] ACC_ONE = {{(ACC_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [ACC_W-1:0] cnt;
        logic [ACC_W-1:0] hold;
    } acc_state_t;

    acc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (latch_evt) begin
            st_d.hold = st_q.cnt;
            st_d.cnt  = count_evt ? ACC_ONE : '0;
        end else if (count_evt && (st_q.cnt != ACC_MAX)) begin
            st_d.cnt = st_q.cnt + ACC_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc      = st_q.cnt;
    assign acc_hold = st_q.hold;

endmodule

// File: rtl/bufcap_capture.sv
module bufcap_capture #(
    parameter int unsigned TIMER_W = bufcap_pkg::DEF_TIMER_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TIMER_W-1:0] timer_val,
    input  logic               cap_evt,
    input  logic               shift_evt,
    input  logic               latch_evt,
    output logic [TIMER_W-1:0] cap,
    output logic [TIMER_W-1:0] hold
);

    typedef struct packed {
        logic [TIMER_W-1:0] cap;
        logic [TIMER_W-1:0] hold;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap_evt) begin
            st_d.cap = timer_val;
        end
        if (latch_evt || shift_evt) begin
            st_d.hold = st_q.cap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cap  = st_q.cap;
    assign hold = st_q.hold;

endmodule

// File: rtl/bufcap_channel.sv
module bufcap_channel
    import bufcap_pkg::*;
#(
    parameter int unsigned TIMER_W     = DEF_TIMER_W,
    parameter int unsigned ACC_W       = DEF_ACC_W,
    parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TIMER_W-1:0] timer_val,
    input  logic               pin_in,
    input  logic [1:0]         edge_sel,
    input  logic               latch_mode,
    input  logic               mdc_zero,
    input  logic               mdc_wzero,
    input  logic               flag_clr,
    output logic [TIMER_W-1:0] cap_val,
    output logic [TIMER_W-1:0] hold_val,
    output logic [ACC_W-1:0]   pacc_val,
    output logic [ACC_W-1:0]   pacc_hold,
    output logic               cap_flag
);

    typedef struct packed {
        logic flag;
    } top_state_t;

    top_state_t st_d, st_q;
    logic       valid_edge;
    logic       latch_evt;
    logic       shift_evt;

    bufcap_edge_det #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_in     (pin_in),
        .edge_sel   (edge_sel),
        .valid_edge (valid_edge)
    );

    // Latch events only exist in latch mode; queue mode shifts per edge.
    always_comb begin
        latch_evt = latch_mode & (mdc_zero | mdc_wzero);
        shift_evt = valid_edge & ~latch_mode;
        st_d      = st_q;
        if (valid_edge) begin
            st_d.flag = 1'b1;
        end else if (flag_clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    bufcap_capture #(
        .TIMER_W (TIMER_W)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .timer_val (timer_val),
        .cap_evt   (valid_edge),
        .shift_evt (shift_evt),
        .latch_evt (latch_evt),
        .cap       (cap_val),
        .hold      (hold_val)
    );

    bufcap_accum #(
        .ACC_W (ACC_W)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_evt (valid_edge),
        .latch_evt (latch_evt),
        .acc       (pacc_val),
        .acc_hold  (pacc_hold)
    );

    assign cap_flag = st_q.flag;

endmodule

// File: rtl/bufcap_chk.sv
module bufcap_chk #(
    parameter int unsigned TIMER_W = 16,
    parameter int unsigned ACC_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [TIMER_W-1:0] timer_val,
    input logic [1:0]         edge_sel,
    input logic               latch_mode,
    input logic               mdc_zero,
    input logic               mdc_wzero,
    input logic [TIMER_W-1:0] cap_val,
    input logic [TIMER_W-1:0] hold_val,
    input logic [ACC_W-1:0]   pacc_val,
    input logic [ACC_W-1:0]   pacc_hold,
    input logic               cap_flag,
    input logic               valid_edge
);

    localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};
    localparam logic [ACC_W-1:0] ACC_ONE = {{(ACC_W-1){1'b0}}, 1'b1};

    logic strobe;
    assign strobe = mdc_zero | mdc_wzero;

    p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel == 2'b00 && !(latch_mode && strobe)) |=> ($stable(cap_val) && $stable(pacc_val)));

    p_queue_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_edge && !latch_mode) |=> (cap_val == $past(timer_val) && hold_val == $past(cap_val)));

    p_latch_nohold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_edge && latch_mode && !strobe) |=> (cap_val == $past(timer_val) && $stable(hold_val)));

    p_latch_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_mode && strobe) |=> (hold_val == $past(cap_val) && pacc_hold == $past(pacc_val)));

    p_latch_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_mode && strobe) |=> (pacc_val == ($past(valid_edge) ? ACC_ONE : '0)));

    p_acc_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pacc_val == ACC_MAX && !(latch_mode && strobe)) |=> (pacc_val == ACC_MAX));

    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_edge |=> cap_flag);

    p_queue_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_mode && strobe && !valid_edge) |=> ($stable(hold_val) && $stable(pacc_hold) && $stable(pacc_val)));

endmodule

bind bufcap_channel bufcap_chk #(
    .TIMER_W (TIMER_W),
    .ACC_W   (ACC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .timer_val  (timer_val),
    .edge_sel   (edge_sel),
    .latch_mode (latch_mode),
    .mdc_zero   (mdc_zero),
    .mdc_wzero  (mdc_wzero),
    .cap_val    (cap_val),
    .hold_val   (hold_val),
    .pacc_val   (pacc_val),
    .pacc_hold  (pacc_hold),
    .cap_flag   (cap_flag),
    .valid_edge (valid_edge)
);

// File: tb/tb_bufcap_channel.sv
module tb_bufcap_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] timer_val = '0;
    logic        pin_in = 1'b0;
    logic [1:0]  edge_sel = '0;
    logic        latch_mode = 1'b0;
    logic        mdc_zero = 1'b0;
    logic        mdc_wzero = 1'b0;
    logic        flag_clr = 1'b0;
    logic [15:0] cap_val, hold_val;
    logic [7:0]  pacc_val, pacc_hold;
    logic        cap_flag;

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    int unsigned cyc = 0;
    bit          done = 1'b0;

    // model state
    logic        m_s1 = 0, m_s2 = 0, m_prev = 0;
    logic [15:0] m_cap = 0, m_hold = 0;
    logic [7:0]  m_acc = 0, m_acch = 0;
    logic        m_flag = 0;

    always #5 clk = ~clk;

    bufcap_channel dut (
        .clk (clk), .rst_n (rst_n), .timer_val (timer_val), .pin_in (pin_in),
        .edge_sel (edge_sel), .latch_mode (latch_mode), .mdc_zero (mdc_zero),
        .mdc_wzero (mdc_wzero), .flag_clr (flag_clr), .cap_val (cap_val),
        .hold_val (hold_val), .pacc_val (pacc_val), .pacc_hold (pacc_hold),
        .cap_flag (cap_flag)
    );

    function automatic logic edge_f(logic cur, logic prv, logic [1:0] es);
        case (es)
            2'b01:   return cur & ~prv;
            2'b10:   return ~cur & prv;
            2'b11:   return cur ^ prv;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] sat_inc(logic [7:0] v);
        return (v == 8'hFF) ? v : v + 8'd1;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Drive at the falling edge, advance the model across one rising edge,
    // compare at the next falling edge.
    task automatic step(logic pin, logic [1:0] es, logic md, logic z, logic wz,
                        logic clr, logic [15:0] tv);
        logic e, lat;
        string tc, th, ta, tah;
        pin_in = pin; edge_sel = es; latch_mode = md;
        mdc_zero = z; mdc_wzero = wz; flag_clr = clr; timer_val = tv;
        e   = edge_f(m_s2, m_prev, es);
        lat = md & (z | wz);
        tc  = (es == 2'b00) ? "R2" : "R3";
        th  = lat ? "R5" : (md ? "R4" : ((z | wz) ? "R9" : "R3"));
        ta  = lat ? "R6" : ((z | wz) ? "R9" : ((es == 2'b00) ? "R2" : "R7"));
        tah = lat ? "R5" : "R9";
        if (lat) begin
            m_hold = m_cap;
            m_acch = m_acc;
            m_acc  = e ? 8'd1 : 8'd0;
        end else begin
            if (e && !md) m_hold = m_cap;
            if (e) m_acc = sat_inc(m_acc);
        end
        if (e) m_cap = tv;
        if (e) m_flag = 1'b1; else if (clr) m_flag = 1'b0;
        m_prev = m_s2; m_s2 = m_s1; m_s1 = pin;
        @(posedge clk);
        @(negedge clk);
        chk(tc, "cap", 32'(cap_val), 32'(m_cap));
        chk(th, "hold", 32'(hold_val), 32'(m_hold));
        chk(ta, "pacc", 32'(pacc_val), 32'(m_acc));
        chk(tah, "pacc_hold", 32'(pacc_hold), 32'(m_acch));
        chk("R8", "flag", 32'(cap_flag), 32'(m_flag));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] t;
        void'($urandom(32'd4242));
        t = 16'h0100;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "cap", 32'(cap_val), 0);
        chk("R1", "hold", 32'(hold_val), 0);
        chk("R1", "pacc", 32'(pacc_val), 0);
        chk("R1", "pacc_hold", 32'(pacc_hold), 0);
        chk("R1", "flag", 32'(cap_flag), 0);

        // R3 directed: rising edge in queue mode, twice
        for (int i = 0; i < 8; i++) begin t++; step(i >= 1, 2'b01, 0, 0, 0, 0, t); end
        for (int i = 0; i < 8; i++) begin t++; step(i < 2 || i > 4, 2'b01, 0, 0, 0, 0, t); end
        // R9: strobes in queue mode
        for (int i = 0; i < 4; i++) begin t++; step(1, 2'b01, 0, 1, i[0], 0, t); end
        // R8: clear flag, then set+clear same clock
        t++; step(1, 2'b01, 0, 0, 0, 1, t);
        for (int i = 0; i < 5; i++) begin t++; step(0, 2'b10, 0, 0, 0, 1, t); end
        // R2: disabled select ignores toggles
        for (int i = 0; i < 12; i++) begin t++; step(i[0], 2'b00, 0, 0, 0, 0, t); end
        // R4/R5/R6: latch mode edges, then strobes incl. simultaneous edge
        for (int i = 0; i < 10; i++) begin t++; step(i[1], 2'b11, 1, 0, 0, 0, t); end
        t++; step(0, 2'b11, 1, 1, 0, 0, t);
        for (int i = 0; i < 6; i++) begin t++; step(i[0], 2'b11, 1, 0, 0, 0, t); end
        t++; step(0, 2'b11, 1, 0, 1, 0, t);
        t++; step(0, 2'b11, 1, 0, 0, 0, t);
        // R7: saturation with both-edge select
        for (int i = 0; i < 300; i++) begin t++; step(i[0], 2'b11, 0, 0, 0, 0, t); end
        for (int i = 0; i < 4; i++) begin t++; step(0, 2'b11, 0, 0, 0, 0, t); end
        chk("R7", "pacc saturated", 32'(pacc_val), 32'h0FF);
        // constrained random
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] ^ r[1] ? r[2] : pin_in, r[4:3], r[5] | r[6],
                 (r[9:7] == 3'd0), (r[12:10] == 3'd0), (r[15:13] == 3'd0), r[31:16]);
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule